// File: doc/BRIEF.md
# Configurable Digital Pin Function Controller

This block turns one general-purpose digital pin of a mixed-signal acquisition device into one of several control functions. A 4-bit function code chooses the role. The pin can be a plain readable input. It can be a wake source that sets a sticky oscillator-enable flag. It can be an active-low override that forces register-driven power enables down. It can be a strobe that loads DAC output registers or steps the channel A FIFO. It can be the acquire/convert control of the ADC. It can also be the direct drive of one analog switch enable.

The pin is resynchronised through a flop chain before any use. Edge-triggered functions then produce one-cycle pulses. Level functions act on the synchronised level. When no function claims a power or switch output, the register-supplied setting passes through unchanged. An edge is only honoured when the function code has held its value since the previous cycle, so reprogramming the code cannot fabricate a strobe.

Top module: `pinfn_ctrl`

## Requirements
- R1: `level_o` equals `pin_i` delayed by two clock cycles (two-flop synchroniser), in every function code including reserved ones. Reset clears it to 0.
- R2: Under code 4'b0001, a synchronised falling edge sets `osc_en_o` one cycle after the edge is seen. Under code 4'b0010, a rising edge does the same. The flag stays set until `osc_clr_i` is high at a clock edge. A set and a clear in the same cycle leave the flag set.
- R3: Under code 4'b0011, while the synchronised level is low, `pwr_o` equals `reg_pwr_i` masked to bit 0 only (bit 0 is the first voltage monitor). While the level is high, `pwr_o` equals `reg_pwr_i`.
- R4: Under code 4'b0100, while the synchronised level is low, `pwr_o` is all zeros. While the level is high, `pwr_o` equals `reg_pwr_i`.
- R5: Under code 4'b0101, a rising edge pulses `dac_b_load_o`. The same edge pulses `dac_a_load_o` when `fifo_a_en_i` is 0, or `fifo_a_adv_o` when it is 1.
- R6: Under code 4'b0111, a rising edge pulses only the channel A output: `dac_a_load_o`, or `fifo_a_adv_o` if `fifo_a_en_i` is 1. Under code 4'b1001, a rising edge pulses only `dac_b_load_o`.
- R7: Under code 4'b0110, a falling edge pulses `adc_acq_o` and a rising edge pulses `adc_conv_o`.
- R8: Each switch code replaces one bit of `sw_o` with the synchronised level. Code 4'b1000 drives bit 0 (DAC A switch), 4'b1010 drives bit 1 (DAC B switch), 4'b1011 drives bit 2 (op-amp 1 switch) and 4'b1100 drives bit 3 (SPDT1). All other bits, and all bits under other codes, equal `reg_sw_i`.
- R9: Under reserved codes 4'b1101 to 4'b1111, all strobes and `osc_en_o` set requests are absent, and `pwr_o`/`sw_o` equal the register inputs.
- R10: Every strobe output is high for single cycles only and never twice in a row.
- R11: An edge is honoured only if `mode_i` equals its value of the previous cycle. In a cycle where the code differs from the last cycle, no strobe or wake set occurs.
- R12: After reset, all strobes, `osc_en_o` and `level_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Raw pin level, asynchronous |
| mode_i | input | 4 | Pin function code |
| fifo_a_en_i | input | 1 | Channel A FIFO enabled |
| osc_clr_i | input | 1 | Clears the oscillator-enable flag |
| reg_pwr_i | input | PWR_W | Register-supplied power enables |
| reg_sw_i | input | 4 | Register-supplied switch enables |
| level_o | output | 1 | Synchronised pin level |
| osc_en_o | output | 1 | Sticky oscillator-enable flag |
| pwr_o | output | PWR_W | Effective power enables |
| sw_o | output | 4 | Effective switch enables |
| dac_a_load_o | output | 1 | DAC A input-to-output load pulse |
| dac_b_load_o | output | 1 | DAC B input-to-output load pulse |
| fifo_a_adv_o | output | 1 | Channel A FIFO advance pulse |
| adc_acq_o | output | 1 | ADC acquisition start pulse |
| adc_conv_o | output | 1 | ADC conversion start pulse |

## Verification
The assertions assume that `mode_i`, `fifo_a_en_i`, `osc_clr_i` and the register inputs are synchronous to `clk`. Only `pin_i` may arrive asynchronously. The properties on edge qualification also assume that the code is stable across the cycles where an edge must be honoured. The stimulus changes every input at the falling clock edge. It holds each function code for runs of cycles and changes it only occasionally. Pin toggles therefore fall both inside stable stretches and right at code changes.

// File: rtl/pinfn_pkg.sv
package pinfn_pkg;
   localparam int MODE_W = 4;
   localparam int SW_W   = 4;

   typedef enum logic [MODE_W-1:0] {
      PM_INPUT     = 4'd0,
      PM_WAKE_FALL = 4'd1,
      PM_WAKE_RISE = 4'd2,
      PM_SLEEP     = 4'd3,
      PM_SHDN      = 4'd4,
      PM_LOAD_AB   = 4'd5,
      PM_CONV      = 4'd6,
      PM_LOAD_A    = 4'd7,
      PM_SW_DACA   = 4'd8,
      PM_LOAD_B    = 4'd9,
      PM_SW_DACB   = 4'd10,
      PM_SW_OA1    = 4'd11,
      PM_SW_SPDT   = 4'd12
   } pin_mode_e;

   localparam int SW_DACA = 0;
   localparam int SW_DACB = 1;
   localparam int SW_OA1  = 2;
   localparam int SW_SPDT = 3;

   typedef struct packed {
      logic dac_a_load;
      logic dac_b_load;
      logic fifo_a_adv;
      logic adc_acq;
      logic adc_conv;
   } strobe_t;
endpackage

// File: rtl/pinfn_sync.sv
module pinfn_sync #(
   parameter int STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          pin_i,
   input  logic [pinfn_pkg::MODE_W-1:0]  mode_i,
   output logic                          level_o,
   output logic                          rise_o,
   output logic                          fall_o
);
   localparam int TOP = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("pinfn_sync: STAGES must be at least 2");
   end

   logic [TOP:0]                   chain_q;
   logic                           prev_q;
   logic [pinfn_pkg::MODE_W-1:0]   mode_q;
   logic                           mode_same;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
         mode_q  <= '0;
      end else begin
         chain_q <= {chain_q[TOP-1:0], pin_i};
         prev_q  <= chain_q[TOP];
         mode_q  <= mode_i;
      end
   end

   assign level_o   = chain_q[TOP];
   assign mode_same = (mode_i == mode_q);
   assign rise_o    = level_o & ~prev_q & mode_same;
   assign fall_o    = ~level_o & prev_q & mode_same;

   // R10
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
   // R10
   fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);
   // R11
   edge_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != $past(mode_i)) |-> !(rise_o || fall_o));
endmodule

// File: rtl/pinfn_decode.sv
module pinfn_decode
   import pinfn_pkg::*;
#(
   parameter int               PWR_W      = 8,
   parameter logic [PWR_W-1:0] SLEEP_KEEP = 1
) (
   input  logic [MODE_W-1:0] mode_i,
   input  logic              level_i,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              fifo_a_en_i,
   input  logic [PWR_W-1:0]  reg_pwr_i,
   input  logic [SW_W-1:0]   reg_sw_i,
   output strobe_t           strobe_o,
   output logic              wake_set_o,
   output logic [PWR_W-1:0]  pwr_o,
   output logic [SW_W-1:0]   sw_o
);
   logic load_a_req;
   logic load_b_req;

   always_comb begin
      load_a_req = 1'b0;
      load_b_req = 1'b0;
      wake_set_o = 1'b0;
      strobe_o   = '0;
      unique case (mode_i)
         PM_WAKE_FALL: wake_set_o = fall_i;
         PM_WAKE_RISE: wake_set_o = rise_i;
         PM_LOAD_AB: begin
            load_a_req = rise_i;
            load_b_req = rise_i;
         end
         PM_LOAD_A:  load_a_req = rise_i;
         PM_LOAD_B:  load_b_req = rise_i;
         PM_CONV: begin
            strobe_o.adc_acq  = fall_i;
            strobe_o.adc_conv = rise_i;
         end
         default: ;
      endcase
      strobe_o.dac_a_load = load_a_req & ~fifo_a_en_i;
      strobe_o.fifo_a_adv = load_a_req & fifo_a_en_i;
      strobe_o.dac_b_load = load_b_req;
   end

   always_comb begin
      pwr_o = reg_pwr_i;
      if (!level_i) begin
         if (mode_i == PM_SLEEP) pwr_o = reg_pwr_i & SLEEP_KEEP;
         if (mode_i == PM_SHDN)  pwr_o = '0;
      end
   end

   always_comb begin
      sw_o = reg_sw_i;
      unique case (mode_i)
         PM_SW_DACA: sw_o[SW_DACA] = level_i;
         PM_SW_DACB: sw_o[SW_DACB] = level_i;
         PM_SW_OA1:  sw_o[SW_OA1]  = level_i;
         PM_SW_SPDT: sw_o[SW_SPDT] = level_i;
         default: ;
      endcase
   end
endmodule

// File: rtl/pinfn_wake.sv
module pinfn_wake #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   if (SET_WINS) begin : g_set_first
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     flag_q <= 1'b0;
         else if (set_i) flag_q <= 1'b1;
         else if (clr_i) flag_q <= 1'b0;
      end
      // R2
      flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_i |=> flag_o);
   end else begin : g_clr_first
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     flag_q <= 1'b0;
         else if (clr_i) flag_q <= 1'b0;
         else if (set_i) flag_q <= 1'b1;
      end
   end

   assign flag_o = flag_q;

   // R2
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);
   // R2
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/pinfn_ctrl.sv
module pinfn_ctrl
   import pinfn_pkg::*;
#(
   parameter int               PWR_W       = 8,
   parameter int               SYNC_STAGES = 2,
   parameter logic [PWR_W-1:0] SLEEP_KEEP  = 1,
   parameter bit               SET_WINS    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_i,
   input  logic [3:0]        mode_i,
   input  logic              fifo_a_en_i,
   input  logic              osc_clr_i,
   input  logic [PWR_W-1:0]  reg_pwr_i,
   input  logic [3:0]        reg_sw_i,
   output logic              level_o,
   output logic              osc_en_o,
   output logic [PWR_W-1:0]  pwr_o,
   output logic [3:0]        sw_o,
   output logic              dac_a_load_o,
   output logic              dac_b_load_o,
   output logic              fifo_a_adv_o,
   output logic              adc_acq_o,
   output logic              adc_conv_o
);
   if (PWR_W < 1) begin : g_bad_pwr
      $error("pinfn_ctrl: PWR_W must be at least 1");
   end

   logic    level;
   logic    rise;
   logic    fall;
   logic    wake_set;
   strobe_t strobe;

   pinfn_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (pin_i),
      .mode_i  (mode_i),
      .level_o (level),
      .rise_o  (rise),
      .fall_o  (fall)
   );

   pinfn_decode #(.PWR_W(PWR_W), .SLEEP_KEEP(SLEEP_KEEP)) u_dec (
      .mode_i      (mode_i),
      .level_i     (level),
      .rise_i      (rise),
      .fall_i      (fall),
      .fifo_a_en_i (fifo_a_en_i),
      .reg_pwr_i   (reg_pwr_i),
      .reg_sw_i    (reg_sw_i),
      .strobe_o    (strobe),
      .wake_set_o  (wake_set),
      .pwr_o       (pwr_o),
      .sw_o        (sw_o)
   );

   pinfn_wake #(.SET_WINS(SET_WINS)) u_wake (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (wake_set),
      .clr_i  (osc_clr_i),
      .flag_o (osc_en_o)
   );

   assign level_o      = level;
   assign dac_a_load_o = strobe.dac_a_load;
   assign dac_b_load_o = strobe.dac_b_load;
   assign fifo_a_adv_o = strobe.fifo_a_adv;
   assign adc_acq_o    = strobe.adc_acq;
   assign adc_conv_o   = strobe.adc_conv;

   // R9
   reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i >= 4'd13) |-> (strobe == '0 && !wake_set &&
                             pwr_o == reg_pwr_i && sw_o == reg_sw_i));
   // R4
   shdn_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 4'd4 && !level_o) |-> (pwr_o == '0));
   // R6
   load_b_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 4'd9) |-> !(dac_a_load_o || fifo_a_adv_o));
   // R5
   fifo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dac_a_load_o && fifo_a_adv_o));
endmodule

// File: tb/sim_pinfn_ctrl.sv
module sim_pinfn_ctrl;
   localparam int PWR_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pin = 1'b0;
   logic [3:0]       mode = 4'd0;
   logic             fifo_en = 1'b0;
   logic             clr = 1'b0;
   logic [PWR_W-1:0] reg_pwr = '0;
   logic [3:0]       reg_sw = '0;
   logic             level, osc_en, dac_a, dac_b, fifo_adv, acq, conv;
   logic [PWR_W-1:0] pwr;
   logic [3:0]       sw;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench-side state
   logic s1 = 0, s2 = 0, prv = 0, osc = 0;
   logic [3:0] mprev = 0;
   logic [4:0] last_strb = 0;

   always #4 clk = ~clk;

   pinfn_ctrl #(.PWR_W(PWR_W)) u0 (
      .clk(clk), .rst_n(rst_n), .pin_i(pin), .mode_i(mode),
      .fifo_a_en_i(fifo_en), .osc_clr_i(clr), .reg_pwr_i(reg_pwr),
      .reg_sw_i(reg_sw), .level_o(level), .osc_en_o(osc_en), .pwr_o(pwr),
      .sw_o(sw), .dac_a_load_o(dac_a), .dac_b_load_o(dac_b),
      .fifo_a_adv_o(fifo_adv), .adc_acq_o(acq), .adc_conv_o(conv));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (mode %0d)", tag, act, exp, mode);
      end
   endtask

   function automatic logic e_rise();
      return s2 & ~prv & (mode == mprev);
   endfunction
   function automatic logic e_fall();
      return ~s2 & prv & (mode == mprev);
   endfunction
   // strobes packed {dac_a, dac_b, fifo_adv, acq, conv}
   function automatic logic [4:0] e_strb();
      logic la, lb;
      la = e_rise() & (mode == 4'd5 || mode == 4'd7);
      lb = e_rise() & (mode == 4'd5 || mode == 4'd9);
      return {la & ~fifo_en, lb, la & fifo_en,
              e_fall() & (mode == 4'd6), e_rise() & (mode == 4'd6)};
   endfunction
   function automatic logic e_wake();
      return (mode == 4'd1 && e_fall()) || (mode == 4'd2 && e_rise());
   endfunction
   function automatic logic [PWR_W-1:0] e_pwr();
      if (mode == 4'd3 && !s2) return reg_pwr & PWR_W'(1);
      if (mode == 4'd4 && !s2) return '0;
      return reg_pwr;
   endfunction
   function automatic logic [3:0] e_sw();
      logic [3:0] v;
      v = reg_sw;
      case (mode)
         4'd8:  v[0] = s2;
         4'd10: v[1] = s2;
         4'd11: v[2] = s2;
         4'd12: v[3] = s2;
         default: ;
      endcase
      return v;
   endfunction

   function automatic string strb_tag();
      if (mode >= 4'd13) return "R9";
      if (mode == 4'd5) return "R5";
      if (mode == 4'd6) return "R7";
      if (mode == 4'd7 || mode == 4'd9) return "R6";
      return "R9";
   endfunction
   function automatic string pwr_tag();
      if (mode == 4'd3) return "R3";
      if (mode == 4'd4) return "R4";
      return "R9";
   endfunction

   task automatic step(input logic p, input logic [3:0] m, input logic f, input logic c);
      logic [4:0] st;
      logic       ws;
      @(negedge clk);
      pin = p; mode = m; fifo_en = f; clr = c;
      reg_pwr = PWR_W'($urandom);
      reg_sw  = 4'($urandom);
      #1;
      st = e_strb();
      chk("R1 level", 32'(level), 32'(s2));
      chk("R2 osc_en", 32'(osc_en), 32'(osc));
      chk({pwr_tag(), " pwr"}, 32'(pwr), 32'(e_pwr()));
      chk("R8 sw", 32'(sw), 32'(e_sw()));
      chk({strb_tag(), " strobes"}, 32'({dac_a, dac_b, fifo_adv, acq, conv}), 32'(st));
      if (mode != mprev)
         chk("R11 no strobe on code change", 32'({dac_a, dac_b, fifo_adv, acq, conv}), 0);
      chk("R10 no repeat strobe",
          32'({dac_a, dac_b, fifo_adv, acq, conv} & last_strb), 0);
      ws = e_wake();
      @(posedge clk);
      last_strb = st;
      osc = ws ? 1'b1 : (c ? 1'b0 : osc);
      prv = s2; s2 = s1; s1 = p; mprev = m;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic p;
      logic [3:0] m;
      logic f;
      void'($urandom(32'h5eed_1234));
      repeat (4) @(posedge clk);
      #1;
      // R12 reset state
      chk("R12 reset level", 32'(level), 0);
      chk("R12 reset osc", 32'(osc_en), 0);
      chk("R12 reset strobes", 32'({dac_a, dac_b, fifo_adv, acq, conv}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      // directed: every code, toggle the pin with settled gaps, both FIFO states
      for (int md = 0; md < 16; md++) begin
         for (int fe = 0; fe < 2; fe++) begin
            for (int k = 0; k < 4; k++) begin
               repeat (4) step(k[0], 4'(md), fe[0], 1'b0);
            end
            step(1'b0, 4'(md), fe[0], 1'b1);
         end
      end
      // directed: R2 set and clear in the same cycle, set wins
      repeat (4) step(1'b1, 4'd1, 1'b0, 1'b0);
      step(1'b0, 4'd1, 1'b0, 1'b0);
      step(1'b0, 4'd1, 1'b0, 1'b0);
      step(1'b0, 4'd1, 1'b0, 1'b1);
      step(1'b0, 4'd1, 1'b0, 1'b0);
      // directed: R11 pin edge lands exactly on a code change
      repeat (4) step(1'b0, 4'd6, 1'b0, 1'b0);
      step(1'b1, 4'd6, 1'b0, 1'b0);
      step(1'b1, 4'd6, 1'b0, 1'b0);
      step(1'b1, 4'd7, 1'b0, 1'b0);
      step(1'b1, 4'd7, 1'b0, 1'b0);
      // random
      p = 0; m = 0; f = 0;
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(15) == 0) m = 4'($urandom);
         if ($urandom_range(2) == 0) p = ~p;
         if ($urandom_range(31) == 0) f = ~f;
         step(p, m, f, $urandom_range(9) == 0);
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule